// File: doc/BRIEF.md
# Composite Sync Separator Filter

This block pulls a vertical sync indication out of a composite sync stream. Horizontal sync pulses are short and vertical intervals are long. A persistence counter therefore rejects every excursion that does not last beyond a programmable number of sample periods. The block runs on its own slow sample clock, a few MHz, and never on the pixel clock. The filtered result is one of two candidate vertical sync sources that logic further on chooses between.

The incoming sync level is already normalised, so high means sync asserted. It first passes through a two-flop synchroniser. The filter holds a state bit. While the synchronised input disagrees with that state, a counter advances. When the counter reaches the threshold, the state flips. Any cycle of agreement clears the counter. Software sets the threshold above the longest line sync pulse, measured in sample periods. A typical value is 32. A final stage either inverts the state or passes it unchanged, under control of a pass-through bit.

Top module: `syncSepFilter`

## Requirements
- R1: The sync input passes through two flops before the filter sees it. With threshold T, a level change presented on `syncIn` before a rising edge reaches the filter state on the (T+3)th rising edge after it is presented.
- R2: The filter state changes only after the synchronised input has differed from it for T+1 consecutive sample cycles.
- R3: Every cycle in which the synchronised input equals the state clears the counter. An excursion of T cycles or fewer leaves the output unchanged. A run that is broken by a single agreeing cycle starts counting again from zero.
- R4: With threshold 0, the output follows the input three rising edges later, which is one edge past the synchroniser.
- R5: The counter never wraps. With threshold 255, a 255-cycle pulse is rejected and a 256-cycle pulse is passed.
- R6: If the threshold is lowered below a count that has already built up, the state flips on the next rising edge.
- R7: When `vsPassThru` is 1, `vsOut` equals the filter state. When it is 0, `vsOut` is the inverse of the state. The bit acts combinationally.
- R8: While `rstN` is low, the counter is zero and the state is 0, so `vsOut` equals the inverse of `vsPassThru`.
- R9: A pulse of T+1 cycles or longer, surrounded by long idle gaps, reappears at the output with exactly its input width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dedicated sample clock |
| rstN | input | 1 | Active-low asynchronous reset |
| syncIn | input | 1 | Normalised composite sync level, 1 = sync asserted |
| threshold | input | 8 | Persistence threshold in sample periods |
| vsPassThru | input | 1 | 1 passes the filter state, 0 inverts it |
| vsOut | output | 1 | Separated vertical sync |

## Verification
The hardest condition to reach from the ports is a counter that holds more than the current threshold. Normal operation clears the count at every flip, so this state never arises on its own. The stimulus builds a long count under a high threshold while the output is held still, then lowers the threshold in a single cycle and expects the flip on the very next edge. A second stimulus breaks an otherwise sufficient run with one agreeing cycle. This shows that a restart discards the partial count rather than resuming it.

// File: rtl/sepPkg.sv
package sepPkg;
  // Strobes from the control decision to the datapath registers; at most one is active.
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic stateFlip;
  } sepStrobe_t;
endpackage

// File: rtl/sepSync.sv
module sepSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stg;
  logic warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= 1'b0;
    else       stg[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[i] <= 1'b0;
        else       stg[i] <= stg[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= 1'b0;
    else       warm <= 1'b1;
  end

  assign dout = stg[STAGES-1];

  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> stg[0] == $past(din)); // R1
endmodule

// File: rtl/sepControl.sv
module sepControl
  import sepPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             syncS,
  input  logic             sepState,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] threshold,
  output sepStrobe_t       strb
);
  logic mismatch;
  logic reached;

  assign mismatch = syncS ^ sepState;
  assign reached  = (cnt >= threshold);

  always_comb begin
    strb = '0;
    if (!mismatch)    strb.cntClr    = 1'b1;
    else if (reached) strb.stateFlip = 1'b1;
    else              strb.cntInc    = 1'b1;
  end
endmodule

// File: rtl/sepDatapath.sv
module sepDatapath
  import sepPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sepStrobe_t       strb,
  output logic [CNT_W-1:0] cnt,
  output logic             sepState
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      sepState <= 1'b0;
    end else if (strb.stateFlip) begin
      cnt      <= '0;
      sepState <= ~sepState;
    end else if (strb.cntClr) begin
      cnt      <= '0;
    end else if (strb.cntInc) begin
      cnt      <= cnt + 1'b1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cntClr, strb.cntInc, strb.stateFlip})); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntInc |-> cnt != '1); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cnt == '0) || (cnt == $past(cnt) + 1'b1)); // R5
endmodule

// File: rtl/syncSepFilter.sv
module syncSepFilter
  import sepPkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] threshold,
  input  logic             vsPassThru,
  output logic             vsOut
);
  logic             syncS;
  logic             sepState;
  logic [CNT_W-1:0] cnt;
  sepStrobe_t       strb;

  sepSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (syncIn),
    .dout(syncS)
  );

  sepControl #(.CNT_W(CNT_W)) uCtrl (
    .syncS    (syncS),
    .sepState (sepState),
    .cnt      (cnt),
    .threshold(threshold),
    .strb     (strb)
  );

  sepDatapath #(.CNT_W(CNT_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cnt     (cnt),
    .sepState(sepState)
  );

  assign vsOut = vsPassThru ? sepState : ~sepState;

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (syncS == sepState) |=> cnt == '0); // R3
  AST_FLIP_AT_THR: assert property (@(posedge clk) disable iff (!rstN)
    (sepState != $past(sepState)) |-> $past(cnt >= threshold)); // R2
  AST_OUT_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    (vsOut ^ sepState) == !vsPassThru); // R7
endmodule

// File: tb/sim_syncSepFilter.sv
`timescale 1ns/1ps
module sim_syncSepFilter;
  logic       clk = 1'b0;
  logic       rstN;
  logic       syncIn;
  logic [7:0] threshold;
  logic       vsPassThru;
  logic       vsOut;
  int         checks = 0;
  int         errors = 0;
  bit         done   = 1'b0;

  always #2.5 clk = ~clk;

  syncSepFilter u0 (
    .clk       (clk),
    .rstN      (rstN),
    .syncIn    (syncIn),
    .threshold (threshold),
    .vsPassThru(vsPassThru),
    .vsOut     (vsOut)
  );

  typedef struct packed {
    logic [7:0] thr;
    logic [8:0] width;
    logic       pass;
    logic       expPass;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'd0,   9'd1,   1'b1, 1'b1},
    '{8'd0,   9'd3,   1'b0, 1'b1},
    '{8'd5,   9'd5,   1'b1, 1'b0},
    '{8'd5,   9'd6,   1'b1, 1'b1},
    '{8'd5,   9'd20,  1'b0, 1'b1},
    '{8'd32,  9'd31,  1'b1, 1'b0},
    '{8'd32,  9'd32,  1'b1, 1'b0},
    '{8'd32,  9'd33,  1'b0, 1'b1},
    '{8'd10,  9'd4,   1'b0, 1'b0},
    '{8'd255, 9'd255, 1'b1, 1'b0},
    '{8'd255, 9'd256, 1'b1, 1'b1}
  };

  function automatic int filtState();
    return (vsPassThru ? vsOut : ~vsOut) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v);
    string tag;
    int first;
    int act;
    tag = (v.thr == 8'd0) ? "R4" : (v.thr == 8'd255) ? "R5" : (v.expPass ? "R2" : "R3");
    threshold  = v.thr;
    vsPassThru = v.pass;
    syncIn     = 1'b0;
    repeat (int'(v.thr) + 8) @(negedge clk);
    check({tag, " idle"}, filtState(), 0);
    syncIn = 1'b1;
    first  = -1;
    act    = 0;
    for (int e = 1; e <= int'(v.width) + int'(v.thr) + 12; e++) begin
      @(negedge clk);
      if (filtState() == 1) begin
        act++;
        if (first < 0) first = e;
      end
      if (e == int'(v.width)) syncIn = 1'b0;
    end
    check({tag, " R9 width"}, act, v.expPass ? int'(v.width) : 0);
    if (v.expPass) check({tag, " R1 delay"}, first, int'(v.thr) + 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int act;
    rstN       = 1'b0;
    syncIn     = 1'b1;
    threshold  = 8'd0;
    vsPassThru = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset out", vsOut, 1);
    vsPassThru = 1'b1;
    #1;
    check("R7 pass in reset", vsOut, 0);
    syncIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 after release", vsOut, 0);

    for (int i = 0; i < NV; i++) runVec(VEC[i]);

    // R3: run broken by a single agreeing cycle restarts
    threshold  = 8'd8;
    vsPassThru = 1'b1;
    syncIn     = 1'b0;
    repeat (12) @(negedge clk);
    act = 0;
    syncIn = 1'b1;
    for (int e = 1; e <= 40; e++) begin
      @(negedge clk);
      act += filtState();
      if (e == 8)  syncIn = 1'b0;
      if (e == 9)  syncIn = 1'b1;
      if (e == 17) syncIn = 1'b0;
    end
    check("R3 restart", act, 0);

    // R6: lower threshold below accumulated count
    threshold = 8'd200;
    syncIn    = 1'b1;
    repeat (100) @(negedge clk);
    check("R6 held", filtState(), 0);
    threshold = 8'd10;
    @(negedge clk);
    check("R6 next edge", filtState(), 1);
    syncIn = 1'b0;
    repeat (20) @(negedge clk);
    check("R6 return", filtState(), 0);

    // R7: invert takes effect at once
    vsPassThru = 1'b0;
    #1;
    check("R7 invert", vsOut, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule